// File: doc/BRIEF.md
# Multi-Register Block Transfer Sequencer

This block carries out one load-multiple or store-multiple operation for a 32-bit core whose address space is 26 bits wide. A command names a 16-bit register-select mask, a base register index, the current value of that base register, the current program-counter/status word, and six flags:

- load or store
- ascending or descending
- step before or after the access
- base write-back
- status update on a program-counter load
- force user bank

The sequencer walks the selected registers from the lowest index to the highest. It issues one word access at a time on a memory request/response port. It updates the register file through one read port and one write port.

The command port is valid/ready. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while the block is idle. The memory request is also valid/ready. While `mem_req_ready` is low, the request and all of its fields are held unchanged. Only one request is outstanding at a time. The response has no back-pressure: `mem_rsp_valid` is taken in any cycle the block is waiting for it.

Aborts are handled in two ways:

- **Store abort:** the remaining stores still run.
- **Load abort:** the previous register write and the base register are rolled back, and the remaining reads still run with their data dropped.

At the end, a single `done` pulse carries at most one exception flag.

Top module: `blkxfer_seq`

## Requirements
- R1: `cmd_ready` is high only in idle; once a command is accepted it stays low until after the `done` pulse, and no memory request is issued while it is high.
- R2: With n selected registers and base address B, the running address starts at B when ascending and at B-4n when descending. Each access uses the running address plus 4 when the pre flag equals the ascending flag, and the running address itself otherwise. The running address grows by 4 per access, so addresses always rise.
- R3: Registers are visited in ascending index order with the program counter (index 15) last. A stalled request holds its address, direction and data stable until accepted.
- R4: When the base index is 15, B is the program-counter word plus 8, and register 15 is never written back.
- R5: With write-back, the base register is written with the final address (B+4n ascending, B-4n descending) right after the first transferred register below 15, and again at the end, even for an empty mask.
- R6: A store of register 15 sends the program-counter word plus 12; any other store sends the register's value as read at issue time.
- R7: A successful load of register 15 raises `pc_wr_en` with the loaded word; `psr_wr_en` is raised with it when the status flag is set, and never otherwise.
- R8: If the start address is at or above 2^26, no store request is issued at all, loads still run, and `exc_addr` is raised at `done` in place of any abort.
- R9: A store abort does not stop the sequence; all remaining stores are issued and `exc_abort` is raised at `done`.
- R10: On the first load abort, its target is not written, the register written by the previous successful load gets its old value back, and a base other than 15 is set to the final address with write-back or to its original value without.
- R11: After a load abort, every remaining selected register still produces a read request, and no loaded data from those reads reaches the register file or the program counter.
- R12: The force-user-bank flag is presented on `rf_user` and `mem_req_user` for every register-file write and memory request of the command.
- R13: Reset leaves the block idle with no pending rollback. `done` is high for exactly one cycle per command, and `exc_addr` and `exc_abort` are never both high and only with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command will be taken |
| cmd_mask | input | 16 | Register-select mask, bit i selects register i |
| cmd_base | input | 4 | Base register index |
| cmd_base_val | input | 32 | Current value of the base register |
| cmd_load | input | 1 | 1 load, 0 store |
| cmd_up | input | 1 | 1 ascending, 0 descending |
| cmd_pre | input | 1 | Pre flag for the step rule |
| cmd_wb | input | 1 | Base write-back enable |
| cmd_psr | input | 1 | Update status bits on program-counter load |
| cmd_user | input | 1 | Force user register bank |
| pc_word | input | 32 | Program-counter word combined with status |
| rf_rd_idx | output | 4 | Register-file read index |
| rf_rd_data | input | 32 | Register-file read data, combinational |
| rf_user | output | 1 | User bank select for both register-file ports |
| rf_wr_en | output | 1 | Register-file write strobe |
| rf_wr_idx | output | 4 | Register-file write index |
| rf_wr_data | output | 32 | Register-file write data |
| pc_wr_en | output | 1 | Program-counter load strobe |
| psr_wr_en | output | 1 | Status update from `pc_wr_data` |
| pc_wr_data | output | 32 | Loaded program-counter word |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 32 | Word address |
| mem_req_write | output | 1 | 1 store, 0 load |
| mem_req_wdata | output | 32 | Store data |
| mem_req_user | output | 1 | Access made with user privilege |
| mem_rsp_valid | input | 1 | Response for the outstanding request |
| mem_rsp_rdata | input | 32 | Load data |
| mem_rsp_abort | input | 1 | Access aborted |
| done | output | 1 | One-cycle completion pulse |
| exc_addr | output | 1 | Address exception, with done |
| exc_abort | output | 1 | Data abort, with done |

## Verification
The register file, the program-counter strobes and the request log all settle before `done`, because the final write-back happens in the cycle before the pulse. The exception flags are valid only in the `done` cycle. The bench therefore waits for `done` at a falling edge. One falling edge later it compares the modelled register file, request log, program-counter writes and captured flags. A second falling edge later it confirms that the pulse lasted exactly one cycle and that `cmd_ready` is back. `cmd_ready` going low is checked at the first falling edge after the command is accepted. The memory model deasserts `mem_req_ready` every fourth cycle and answers one cycle after each accepted request, so back-pressure and response waits occur in every sweep.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ISSUE,
    S_WAIT,
    S_ROLL,
    S_BFIX,
    S_WB1,
    S_WBEND,
    S_DONE
  } xfer_st_t;

  function automatic logic [5:0] popcnt32(input logic [31:0] v);
    logic [5:0] c;
    c = '0;
    for (int i = 0; i < 32; i++) c = c + {5'd0, v[i]};
    return c;
  endfunction

endpackage

// File: rtl/blkxfer_pick.sv
module blkxfer_pick #(
  parameter int NREG = 16,
  localparam int IW = $clog2(NREG)
) (
  input  logic [NREG-1:0] pend,
  output logic [NREG-1:0] onehot,
  output logic [IW-1:0]   idx,
  output logic            any
);
  assign onehot = pend & (~pend + 1'b1);
  assign any    = |pend;

  for (genvar b = 0; b < IW; b++) begin : g_enc
    logic [NREG-1:0] sel;
    for (genvar i = 0; i < NREG; i++) begin : g_sel
      if (((i >> b) & 1) == 1) begin : g_on
        assign sel[i] = onehot[i];
      end else begin : g_off
        assign sel[i] = 1'b0;
      end
    end
    assign idx[b] = |sel;
  end
endmodule

// File: rtl/blkxfer_addr.sv
module blkxfer_addr #(
  parameter int DW = 32,
  parameter int AW = 26,
  parameter int CW = 5
) (
  input  logic [DW-1:0] base,
  input  logic [CW-1:0] cnt,
  input  logic          up,
  output logic [DW-1:0] start,
  output logic [DW-1:0] fin,
  output logic          aerr
);
  logic [DW-1:0] span;
  assign span  = {{(DW-CW-2){1'b0}}, cnt, 2'b00};
  assign fin   = up ? base + span : base - span;
  assign start = up ? base : base - span;
  assign aerr  = |start[DW-1:AW];
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
  import blkxfer_pkg::*;
#(
  parameter int NREG = 16,
  parameter int DW   = 32,
  parameter int AW   = 26,
  localparam int IW  = $clog2(NREG),
  localparam int CW  = $clog2(NREG + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [NREG-1:0] cmd_mask,
  input  logic [IW-1:0]   cmd_base,
  input  logic [DW-1:0]   cmd_base_val,
  input  logic            cmd_load,
  input  logic            cmd_up,
  input  logic            cmd_pre,
  input  logic            cmd_wb,
  input  logic            cmd_psr,
  input  logic            cmd_user,
  input  logic [DW-1:0]   pc_word,
  output logic [IW-1:0]   rf_rd_idx,
  input  logic [DW-1:0]   rf_rd_data,
  output logic            rf_user,
  output logic            rf_wr_en,
  output logic [IW-1:0]   rf_wr_idx,
  output logic [DW-1:0]   rf_wr_data,
  output logic            pc_wr_en,
  output logic            psr_wr_en,
  output logic [DW-1:0]   pc_wr_data,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [DW-1:0]   mem_req_addr,
  output logic            mem_req_write,
  output logic [DW-1:0]   mem_req_wdata,
  output logic            mem_req_user,
  input  logic            mem_rsp_valid,
  input  logic [DW-1:0]   mem_rsp_rdata,
  input  logic            mem_rsp_abort,
  output logic            done,
  output logic            exc_addr,
  output logic            exc_abort
);
  localparam logic [IW-1:0] PC_IDX = IW'(NREG - 1);
  localparam logic [DW-1:0] STEP   = DW'(4);
  localparam logic [DW-1:0] PC_RD  = DW'(8);
  localparam logic [DW-1:0] PC_ST  = DW'(12);

  xfer_st_t        st_q;
  logic [NREG-1:0] pend_q;
  logic [IW-1:0]   bidx_q, cur_idx_q, last_idx_q;
  logic [DW-1:0]   pcw_q, orig_q, fin_q, addr_q, cur_old_q, last_old_q;
  logic            load_q, up_q, pre_q, wb_q, psr_q, user_q;
  logic            aerr_q, abt_q, dead_q, first_q, lastv_q;

  // next-register selection
  logic [NREG-1:0] pick_oh;
  logic [IW-1:0]   pick_idx;
  logic            pick_any;

  blkxfer_pick #(.NREG(NREG)) u_pick (
    .pend   (pend_q),
    .onehot (pick_oh),
    .idx    (pick_idx),
    .any    (pick_any)
  );

  // command-time address arithmetic
  logic [CW-1:0] cmd_cnt;
  logic [DW-1:0] cmd_basea, cmd_start, cmd_fin;
  logic          cmd_aerr;

  assign cmd_cnt   = CW'(popcnt32(32'(cmd_mask)));
  assign cmd_basea = (cmd_base == PC_IDX) ? pc_word + PC_RD : cmd_base_val;

  blkxfer_addr #(.DW(DW), .AW(AW), .CW(CW)) u_addr (
    .base  (cmd_basea),
    .cnt   (cmd_cnt),
    .up    (cmd_up),
    .start (cmd_start),
    .fin   (cmd_fin),
    .aerr  (cmd_aerr)
  );

  // combinational view of the current step
  logic base_pc, pick_pc, cur_pc, suppress, load_ok, wb1_issue, wb1_wait;

  assign base_pc   = (bidx_q == PC_IDX);
  assign pick_pc   = (pick_idx == PC_IDX);
  assign cur_pc    = (cur_idx_q == PC_IDX);
  assign suppress  = !load_q && aerr_q;
  assign load_ok   = (st_q == S_WAIT) && mem_rsp_valid && load_q && !dead_q && !mem_rsp_abort;
  assign wb1_issue = first_q && wb_q && !base_pc && !pick_pc;
  assign wb1_wait  = first_q && wb_q && !base_pc && !cur_pc;

  assign cmd_ready     = (st_q == S_IDLE);
  assign rf_rd_idx     = pick_idx;
  assign rf_user       = user_q;
  assign mem_req_user  = user_q;
  assign mem_req_valid = (st_q == S_ISSUE) && pick_any && !suppress;
  assign mem_req_addr  = (pre_q == up_q) ? addr_q + STEP : addr_q;
  assign mem_req_write = !load_q;
  assign mem_req_wdata = pick_pc ? pcw_q + PC_ST : rf_rd_data;

  assign pc_wr_en   = load_ok && cur_pc;
  assign psr_wr_en  = pc_wr_en && psr_q;
  assign pc_wr_data = mem_rsp_rdata;

  assign done      = (st_q == S_DONE);
  assign exc_addr  = done && aerr_q;
  assign exc_abort = done && abt_q && !aerr_q;

  always_comb begin
    rf_wr_en   = 1'b0;
    rf_wr_idx  = bidx_q;
    rf_wr_data = fin_q;
    unique case (st_q)
      S_WAIT: begin
        if (load_ok && !cur_pc) begin
          rf_wr_en   = 1'b1;
          rf_wr_idx  = cur_idx_q;
          rf_wr_data = mem_rsp_rdata;
        end
      end
      S_ROLL: begin
        if (lastv_q) begin
          rf_wr_en   = 1'b1;
          rf_wr_idx  = last_idx_q;
          rf_wr_data = last_old_q;
        end
      end
      S_BFIX: begin
        rf_wr_en   = !base_pc;
        rf_wr_data = wb_q ? fin_q : orig_q;
      end
      S_WB1:   rf_wr_en = 1'b1;
      S_WBEND: rf_wr_en = wb_q && !base_pc;
      default: rf_wr_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      pend_q     <= '0;
      bidx_q     <= '0;
      cur_idx_q  <= '0;
      last_idx_q <= '0;
      pcw_q      <= '0;
      orig_q     <= '0;
      fin_q      <= '0;
      addr_q     <= '0;
      cur_old_q  <= '0;
      last_old_q <= '0;
      load_q     <= 1'b0;
      up_q       <= 1'b0;
      pre_q      <= 1'b0;
      wb_q       <= 1'b0;
      psr_q      <= 1'b0;
      user_q     <= 1'b0;
      aerr_q     <= 1'b0;
      abt_q      <= 1'b0;
      dead_q     <= 1'b0;
      first_q    <= 1'b0;
      lastv_q    <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: begin
          if (cmd_valid) begin
            pend_q  <= cmd_mask;
            bidx_q  <= cmd_base;
            pcw_q   <= pc_word;
            orig_q  <= cmd_base_val;
            fin_q   <= cmd_fin;
            addr_q  <= cmd_start;
            aerr_q  <= cmd_aerr;
            load_q  <= cmd_load;
            up_q    <= cmd_up;
            pre_q   <= cmd_pre;
            wb_q    <= cmd_wb;
            psr_q   <= cmd_psr;
            user_q  <= cmd_user;
            abt_q   <= 1'b0;
            dead_q  <= 1'b0;
            first_q <= 1'b1;
            lastv_q <= 1'b0;
            st_q    <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          if (!pick_any) begin
            st_q <= S_WBEND;
          end else if (suppress) begin
            pend_q  <= pend_q & ~pick_oh;
            addr_q  <= addr_q + STEP;
            first_q <= 1'b0;
            st_q    <= wb1_issue ? S_WB1 : S_ISSUE;
          end else if (mem_req_ready) begin
            pend_q    <= pend_q & ~pick_oh;
            addr_q    <= addr_q + STEP;
            cur_idx_q <= pick_idx;
            cur_old_q <= rf_rd_data;
            st_q      <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (mem_rsp_valid) begin
            first_q <= 1'b0;
            if (load_q && !dead_q && mem_rsp_abort) begin
              abt_q  <= 1'b1;
              dead_q <= 1'b1;
              st_q   <= S_ROLL;
            end else begin
              if (!load_q && mem_rsp_abort) abt_q <= 1'b1;
              if (load_ok && !cur_pc) begin
                lastv_q    <= 1'b1;
                last_idx_q <= cur_idx_q;
                last_old_q <= cur_old_q;
              end
              st_q <= wb1_wait ? S_WB1 : S_ISSUE;
            end
          end
        end
        S_ROLL: begin
          lastv_q <= 1'b0;
          st_q    <= S_BFIX;
        end
        S_BFIX:  st_q <= S_ISSUE;
        S_WB1:   st_q <= S_ISSUE;
        S_WBEND: st_q <= S_DONE;
        S_DONE: begin
          dead_q  <= 1'b0;
          lastv_q <= 1'b0;
          st_q    <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blkxfer_chk.sv
module blkxfer_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_ready,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [DW-1:0] mem_req_addr,
  input logic          mem_req_write,
  input logic          pc_wr_en,
  input logic          psr_wr_en,
  input logic          done,
  input logic          exc_addr,
  input logic          exc_abort
);
  // R13: completion is a single-cycle pulse
  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R13: never both exception flags
  p_exc_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_addr && exc_abort));

  // R13: exception flags only alongside done
  p_exc_done_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_addr || exc_abort) |-> done);

  // R3: a stalled request holds still
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

  // R7: status update only with a program-counter load
  p_psr_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    psr_wr_en |-> pc_wr_en);

  // R1: no memory traffic while idle
  p_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !cmd_ready);
endmodule

bind blkxfer_seq blkxfer_chk #(.DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_ready     (cmd_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_req_write (mem_req_write),
  .pc_wr_en      (pc_wr_en),
  .psr_wr_en     (psr_wr_en),
  .done          (done),
  .exc_addr      (exc_addr),
  .exc_abort     (exc_abort)
);

// File: tb/tb_blkxfer_seq.sv
module tb_blkxfer_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cmd_valid = 1'b0, cmd_ready;
  logic [15:0] cmd_mask = '0;
  logic [3:0]  cmd_base = '0;
  logic [31:0] cmd_base_val = '0, pc_word = '0;
  logic cmd_load = 0, cmd_up = 0, cmd_pre = 0, cmd_wb = 0, cmd_psr = 0, cmd_user = 0;
  logic [3:0]  rf_rd_idx, rf_wr_idx;
  logic [31:0] rf_rd_data, rf_wr_data, pc_wr_data;
  logic        rf_user, rf_wr_en, pc_wr_en, psr_wr_en;
  logic        mem_req_valid, mem_req_ready, mem_req_write, mem_req_user;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0, mem_rsp_abort = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;
  logic        done, exc_addr, exc_abort;

  blkxfer_seq dut (.*);

  int checks = 0, fails = 0;
  int cyc = 0;
  logic [31:0] rf_m [16];
  logic [31:0] init_v [16];
  logic        rf_load = 0, log_clr = 0, cur_user = 0;
  int          abort_at = -1;
  logic [31:0] la [32], ldat [32];
  logic        lw [32];
  int          log_n = 0, user_err = 0, done_n = 0;
  logic        pc_seen = 0, psr_seen = 0, xa = 0, xb = 0;
  logic [31:0] pc_got = '0;

  assign rf_rd_data    = rf_m[rf_rd_idx];
  assign mem_req_ready = (cyc[1:0] != 2'b11);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rf_load) begin
      for (int i = 0; i < 16; i++) rf_m[i] <= init_v[i];
    end else if (rf_wr_en) begin
      rf_m[rf_wr_idx] <= rf_wr_data;
    end
    if (log_clr) begin
      log_n <= 0; user_err <= 0; done_n <= 0;
      pc_seen <= 0; psr_seen <= 0; mem_rsp_valid <= 0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        if (log_n < 32) begin
          la[log_n] <= mem_req_addr; ldat[log_n] <= mem_req_wdata; lw[log_n] <= mem_req_write;
        end
        log_n         <= log_n + 1;
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= mem_req_addr ^ 32'h5A5A_0000;
        mem_rsp_abort <= (log_n == abort_at);
      end
      if ((rf_wr_en && rf_user !== cur_user) || (mem_req_valid && mem_req_user !== cur_user))
        user_err <= user_err + 1;
      if (pc_wr_en) begin pc_seen <= 1'b1; pc_got <= pc_wr_data; end
      if (psr_wr_en) psr_seen <= 1'b1;
      if (done) begin done_n <= done_n + 1; xa <= exc_addr; xb <= exc_abort; end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference results
  logic [31:0] erf [16], ea [16], ed [16];
  logic        ew [16];
  int          ecnt;
  logic        eaerr, eabt, epc_seen, epsr;
  logic [31:0] epc;

  task automatic model(input logic [15:0] m, input int bi, input bit ld, up, pr, wb, ps,
                       input int ab, input logic [31:0] pcw);
    int n = 0, last = 0;
    logic [31:0] base, orig, fin, a, ar, lastold;
    bit first = 1, dead = 0, lastv = 0;
    lastold = '0;
    for (int i = 0; i < 16; i++) begin erf[i] = init_v[i]; n += int'(m[i]); end
    orig = init_v[bi];
    base = (bi == 15) ? pcw + 8 : orig;
    fin  = up ? base + 32'(4 * n) : base - 32'(4 * n);
    a    = up ? base : base - 32'(4 * n);
    eaerr = (a >> 26) != 0; eabt = 0; ecnt = 0; epc_seen = 0; epsr = 0; epc = '0;
    for (int i = 0; i < 16; i++) begin
      if (m[i]) begin
        ar = (pr == up) ? a + 4 : a;
        a  = a + 4;
        if (!ld) begin
          if (!eaerr) begin
            ea[ecnt] = ar; ew[ecnt] = 1'b1;
            ed[ecnt] = (i == 15) ? pcw + 12 : erf[i];
            if (ecnt == ab) eabt = 1;
            ecnt++;
          end
        end else begin
          ea[ecnt] = ar; ew[ecnt] = 1'b0; ed[ecnt] = '0;
          if (!dead) begin
            if (ecnt == ab) begin
              dead = 1; eabt = 1;
              if (lastv) erf[last] = lastold;
              if (bi != 15) erf[bi] = wb ? fin : orig;
            end else if (i == 15) begin
              epc_seen = 1; epc = ar ^ 32'h5A5A_0000; epsr = ps;
            end else begin
              lastold = erf[i]; erf[i] = ar ^ 32'h5A5A_0000; lastv = 1; last = i;
            end
          end
          ecnt++;
        end
        if (first && wb && bi != 15 && i != 15) erf[bi] = fin;
        first = 0;
      end
    end
    if (wb && bi != 15) erf[bi] = fin;
  endtask

  task automatic run(input logic [15:0] m, input int bi, input bit ld, up, pr, wb, ps, us,
                     input bit hi, input int ab);
    logic [31:0] pcw;
    bit ok;
    int wd;
    pcw = hi ? 32'h0400_0038 : 32'h0000_2000;
    for (int i = 0; i < 16; i++) init_v[i] = 32'h0000_1000 + 32'(i * 64);
    if (bi != 15) init_v[bi] = hi ? 32'h0400_0040 : 32'h0000_3000;
    @(negedge clk);
    rf_load = 1; log_clr = 1; abort_at = ab; cur_user = us;
    @(negedge clk);
    rf_load = 0; log_clr = 0;
    model(m, bi, ld, up, pr, wb, ps, ab, pcw);
    cmd_mask = m; cmd_base = 4'(bi); cmd_base_val = init_v[bi]; pc_word = pcw;
    cmd_load = ld; cmd_up = up; cmd_pre = pr; cmd_wb = wb; cmd_psr = ps; cmd_user = us;
    cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    chk(cmd_ready == 1'b0, "R1 busy after accept", 32'(cmd_ready), 32'h0);
    wd = 0;
    while (!done && wd < 400) begin @(negedge clk); wd++; end
    chk(wd < 400, "R13 done reached", 32'(wd), 32'd400);
    @(negedge clk);
    chk(xa == eaerr, "R8 exc_addr", 32'(xa), 32'(eaerr));
    chk(xb == (eabt && !eaerr), "R9 R10 exc_abort", 32'(xb), 32'(eabt && !eaerr));
    ok = 1;
    for (int i = 0; i < 16; i++) if (rf_m[i] !== erf[i]) ok = 0;
    chk(ok, "R5 R10 R4 register file", rf_m[bi], erf[bi]);
    chk(log_n == ecnt, "R2 R8 R11 request count", 32'(log_n), 32'(ecnt));
    ok = 1;
    for (int k = 0; k < 16; k++)
      if (k < ecnt && k < log_n)
        if (la[k] !== ea[k] || lw[k] !== ew[k] || (ew[k] && ldat[k] !== ed[k])) ok = 0;
    chk(ok, "R2 R3 R6 request sequence", la[0], ea[0]);
    chk(pc_seen == epc_seen && (!epc_seen || pc_got == epc), "R7 R11 pc load", pc_got, epc);
    chk(psr_seen == (epc_seen && epsr), "R7 psr load", 32'(psr_seen), 32'(epc_seen && epsr));
    chk(user_err == 0, "R12 user bank", 32'(user_err), 32'h0);
    @(negedge clk);
    chk(done_n == 1, "R13 single done", 32'(done_n), 32'd1);
    chk(cmd_ready == 1'b1, "R1 ready after done", 32'(cmd_ready), 32'h1);
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] masks [8];
    int bases [3];
    masks = '{16'h0000, 16'h0001, 16'h0006, 16'h8000, 16'h8421, 16'hFFFF, 16'h4010, 16'h0F0F};
    bases = '{2, 13, 15};
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b1 && done == 1'b0, "R13 reset idle", 32'({cmd_ready, done}), 32'h2);
    chk(mem_req_valid == 1'b0 && rf_wr_en == 1'b0, "R13 reset quiet",
        32'({mem_req_valid, rf_wr_en}), 32'h0);
    rst_n = 1;
    for (int mi = 0; mi < 8; mi++)
      for (int bs = 0; bs < 3; bs++)
        for (int f = 0; f < 16; f++)
          for (int v = 0; v < 3; v++)
            run(masks[mi], bases[bs], f[0], f[1], f[2], f[3], f[2], f[1] ^ f[3],
                v == 2, (v == 1) ? 1 : -1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule